// File: doc/BRIEF.md
# EEPROM Byte Update Sequencer

This controller sits on the host side of a byte-wide electrically erasable memory whose address, data and control inputs are latched inside the part. It accepts one update request at a time over a valid/ready handshake. Each request carries an address and a data byte. The controller then drives the memory pins through a fixed two-phase programme.

In the first phase the byte is cleared: the controller presents all-ones data and pulses write-enable low while chip-enable is low and output-enable is high. It then waits out the programming time. The second phase is identical except that the requested data is presented. After each phase's wait, the controller runs one memory read cycle and discards its data. That read releases an external write-enable latch of the kind used in glue-logic write circuits.

When the verify option is on, the controller reads the byte back once more and flags a mismatch. It signals completion with a one-cycle pulse. The pulse width, programming wait and read length are all derived from a clock-frequency parameter and times in nanoseconds or microseconds.

Top module: `ee_byte_updater`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle; in the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `req_ready` is low, and it stays low until the completion pulse has ended.
- R2: Every update produces exactly two write-enable low pulses to the requested address. The first (the erase) carries the all-ones byte (8'hFF for 8-bit data) on `ee_dq_o`, so the byte is cleared before it is written.
- R3: Whenever `ee_we_n` is low, `ee_ce_n` is low, `ee_oe_n` is high and `ee_dq_oe` is high. The data bus is never driven while `ee_oe_n` is low.
- R4: Each write-enable low pulse lasts exactly PULSE_CYC = max(1, ceil(WE_NS*CLK_HZ/1e9)) cycles. Address, data and the enables are settled one cycle before the falling edge and are held one cycle after the rising edge.
- R5: After a write-enable pulse, at least WAIT_CYC = ceil(PROG_US*CLK_HZ/1e6) cycles with `ee_ce_n` high pass before the next read cycle (`ee_ce_n` and `ee_oe_n` both low).
- R6: Each write-enable pulse is followed by a read cycle before the next write-enable falling edge. The data of that read is discarded.
- R7: The second pulse uses the same address and carries the requested data. When the update completes, the byte holds the requested value.
- R8: With VERIFY_EN=1, a read-back after the write sets `upd_err` together with `upd_done` exactly when the value read differs from the requested data. `upd_done` is a one-cycle pulse. `upd_err` holds until the next request is accepted.
- R9: The completion pulse appears a fixed number of cycles after the accepting edge: 2*(PULSE_CYC+2) + 2*WAIT_CYC + 2*RD_CYC, plus RD_CYC+2 when VERIFY_EN=1, where RD_CYC = max(1, ceil(RD_NS*CLK_HZ/1e9)).
- R10: While `rst` is high, `ee_ce_n`, `ee_oe_n` and `ee_we_n` are high, `ee_dq_oe` is low, `req_ready` is high, and `upd_done` and `upd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | AW | Byte address to update |
| req_data | input | DW | New byte value |
| upd_done | output | 1 | One-cycle completion pulse |
| upd_err | output | 1 | Read-back mismatch of the last update |
| ee_addr | output | AW | Memory address pins |
| ee_dq_o | output | DW | Data driven toward the memory |
| ee_dq_oe | output | 1 | Drive enable for `ee_dq_o` |
| ee_dq_i | input | DW | Data read from the memory |
| ee_ce_n | output | 1 | Chip enable, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write enable, active low |

## Verification
The bench memory model samples the registered pins at each rising edge and enforces the pin rules as they happen: gating during the pulse, pulse width, idle wait and the dummy read. It tallies violations, and the scoreboard requires the tallies to stay at zero.

`upd_done` is due exactly the R9 count of cycles after the accepting edge. The monitor reads outputs on falling edges and compares that latency against a rising-edge counter. At the same sample it checks `upd_err`, the stored byte and the number of write pulses.

Reset values are read on a falling edge while reset is held.

// File: rtl/ee_upd_pkg.sv
package ee_upd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE_PULSE,
    ST_ERASE_WAIT,
    ST_CLR_READ1,
    ST_WRITE_PULSE,
    ST_WRITE_WAIT,
    ST_CLR_READ2,
    ST_VERIFY,
    ST_DONE
  } upd_state_t;

  // Control pins toward the memory, all strobes active low.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } ee_ctl_t;

  localparam ee_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  // Cycles covering a time given in units of 1/scale seconds, rounded up.
  function automatic int unsigned time_to_cyc(longint unsigned t, longint unsigned hz,
                                              longint unsigned scale);
    return 32'((t * hz + scale - 64'd1) / scale);
  endfunction

  function automatic int unsigned at_least_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/ee_upd_timer.sv
module ee_upd_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ee_upd_fsm.sv
module ee_upd_fsm
  import ee_upd_pkg::*;
#(
  parameter int unsigned AW        = 11,
  parameter int unsigned DW        = 8,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned WAIT_CYC  = 1,
  parameter int unsigned RD_CYC    = 1,
  parameter bit          VERIFY_EN = 1'b1,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          upd_done,
  output logic          upd_err,
  input  logic [DW-1:0] rd_data,
  input  logic [CW-1:0] tm_cnt,
  input  logic          tm_zero,
  output logic          tm_load,
  output logic [CW-1:0] tm_val,
  output ee_ctl_t       cmd_ctl,
  output logic [DW-1:0] cmd_dat,
  output logic [AW-1:0] cmd_addr
);

  // Pulse state: one setup cycle, PULSE_CYC low cycles, one hold cycle.
  localparam logic [CW-1:0] PULSE_INIT = CW'(PULSE_CYC + 1);
  localparam logic [CW-1:0] WAIT_INIT  = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] RD_INIT    = CW'(RD_CYC - 1);
  // Verify: one idle cycle to separate it from the dummy read.
  localparam logic [CW-1:0] VFY_INIT   = CW'(RD_CYC + 1);

  upd_state_t    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign upd_done  = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_ERASE_PULSE; tm_load = 1'b1; tm_val = PULSE_INIT;
      end
      ST_ERASE_PULSE: if (tm_zero) begin
        state_d = ST_ERASE_WAIT; tm_load = 1'b1; tm_val = WAIT_INIT;
      end
      ST_ERASE_WAIT: if (tm_zero) begin
        state_d = ST_CLR_READ1; tm_load = 1'b1; tm_val = RD_INIT;
      end
      ST_CLR_READ1: if (tm_zero) begin
        state_d = ST_WRITE_PULSE; tm_load = 1'b1; tm_val = PULSE_INIT;
      end
      ST_WRITE_PULSE: if (tm_zero) begin
        state_d = ST_WRITE_WAIT; tm_load = 1'b1; tm_val = WAIT_INIT;
      end
      ST_WRITE_WAIT: if (tm_zero) begin
        state_d = ST_CLR_READ2; tm_load = 1'b1; tm_val = RD_INIT;
      end
      ST_CLR_READ2: if (tm_zero) begin
        if (VERIFY_EN) begin
          state_d = ST_VERIFY; tm_load = 1'b1; tm_val = VFY_INIT;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_VERIFY: if (tm_zero) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  generate
    if (VERIFY_EN) begin : g_verify
      logic err_q;
      always_ff @(posedge clk) begin
        if (rst)                                 err_q <= 1'b0;
        else if (accept)                         err_q <= 1'b0;
        else if (state_q == ST_VERIFY && tm_zero) err_q <= (rd_data != data_q);
      end
      assign upd_err = err_q;
    end else begin : g_no_verify
      logic unused_rd;
      assign unused_rd = ^rd_data;
      assign upd_err   = 1'b0;
    end
  endgenerate

  // Pin command for the next cycle; registered in the pin stage.
  always_comb begin
    cmd_ctl  = CTL_IDLE;
    cmd_dat  = data_q;
    cmd_addr = addr_q;
    unique case (state_q)
      ST_ERASE_PULSE, ST_WRITE_PULSE: begin
        cmd_ctl.ce_n = 1'b0;
        cmd_ctl.drv  = 1'b1;
        cmd_ctl.we_n = (tm_cnt == PULSE_INIT) || tm_zero;
        cmd_dat      = (state_q == ST_ERASE_PULSE) ? '1 : data_q;
      end
      ST_CLR_READ1, ST_CLR_READ2: begin
        cmd_ctl.ce_n = 1'b0;
        cmd_ctl.oe_n = 1'b0;
      end
      ST_VERIFY: if (tm_cnt != VFY_INIT) begin
        cmd_ctl.ce_n = 1'b0;
        cmd_ctl.oe_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ee_upd_pins.sv
module ee_upd_pins
  import ee_upd_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ee_ctl_t       cmd_ctl,
  input  logic [DW-1:0] cmd_dat,
  input  logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_dq_o,
  output logic          ee_dq_oe,
  output logic          ee_ce_n,
  output logic          ee_oe_n,
  output logic          ee_we_n
);

  ee_ctl_t       ctl_q;
  logic [DW-1:0] dat_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_IDLE;
      dat_q  <= '0;
      addr_q <= '0;
    end else begin
      ctl_q  <= cmd_ctl;
      dat_q  <= cmd_dat;
      addr_q <= cmd_addr;
    end
  end

  assign ee_addr  = addr_q;
  assign ee_dq_o  = dat_q;
  assign ee_dq_oe = ctl_q.drv;
  assign ee_ce_n  = ctl_q.ce_n;
  assign ee_oe_n  = ctl_q.oe_n;
  assign ee_we_n  = ctl_q.we_n;

endmodule

// File: rtl/ee_byte_updater.sv
module ee_byte_updater
  import ee_upd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned AW        = 11,
  parameter int unsigned DW        = 8,
  parameter int unsigned PROG_US   = 10_000,
  parameter int unsigned WE_NS     = 200,
  parameter int unsigned RD_NS     = 250,
  parameter bit          VERIFY_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          upd_done,
  output logic          upd_err,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_dq_o,
  output logic          ee_dq_oe,
  input  logic [DW-1:0] ee_dq_i,
  output logic          ee_ce_n,
  output logic          ee_oe_n,
  output logic          ee_we_n
);

  localparam int unsigned PULSE_CYC =
    at_least_one(time_to_cyc(64'(WE_NS), 64'(CLK_HZ), 64'd1_000_000_000));
  localparam int unsigned WAIT_CYC =
    at_least_one(time_to_cyc(64'(PROG_US), 64'(CLK_HZ), 64'd1_000_000));
  localparam int unsigned RD_CYC =
    at_least_one(time_to_cyc(64'(RD_NS), 64'(CLK_HZ), 64'd1_000_000_000));
  localparam int unsigned LONG_A  = (PULSE_CYC > RD_CYC) ? PULSE_CYC : RD_CYC;
  localparam int unsigned LONGEST = ((LONG_A + 2) > WAIT_CYC) ? (LONG_A + 2) : WAIT_CYC;
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  logic          tm_load, tm_zero;
  logic [CW-1:0] tm_val, tm_cnt;
  ee_ctl_t       cmd_ctl;
  logic [DW-1:0] cmd_dat;
  logic [AW-1:0] cmd_addr;

  ee_upd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val),
    .cnt(tm_cnt), .zero(tm_zero)
  );

  ee_upd_fsm #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .WAIT_CYC(WAIT_CYC),
    .RD_CYC(RD_CYC), .VERIFY_EN(VERIFY_EN), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .upd_done(upd_done), .upd_err(upd_err),
    .rd_data(ee_dq_i),
    .tm_cnt(tm_cnt), .tm_zero(tm_zero), .tm_load(tm_load), .tm_val(tm_val),
    .cmd_ctl(cmd_ctl), .cmd_dat(cmd_dat), .cmd_addr(cmd_addr)
  );

  ee_upd_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst),
    .cmd_ctl(cmd_ctl), .cmd_dat(cmd_dat), .cmd_addr(cmd_addr),
    .ee_addr(ee_addr), .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n)
  );

endmodule

// File: rtl/ee_byte_updater_chk.sv
module ee_byte_updater_chk #(
  parameter int unsigned AW        = 11,
  parameter int unsigned DW        = 8,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned WAIT_CYC  = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          upd_done,
  input logic [AW-1:0] ee_addr,
  input logic [DW-1:0] ee_dq_o,
  input logic          ee_dq_oe,
  input logic          ee_ce_n,
  input logic          ee_oe_n,
  input logic          ee_we_n
);

  logic [31:0] low_cnt;
  logic [31:0] idle_cnt;
  logic        pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      idle_cnt <= WAIT_CYC;
      pend     <= 1'b0;
    end else begin
      low_cnt <= ee_we_n ? '0 : low_cnt + 1;
      if (!ee_we_n)                          idle_cnt <= '0;
      else if (ee_ce_n && idle_cnt < WAIT_CYC) idle_cnt <= idle_cnt + 1;
      if (!ee_we_n)                          pend <= 1'b1;
      else if (!ee_ce_n && !ee_oe_n)         pend <= 1'b0;
    end
  end

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_we_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n && ee_dq_oe));

  p_no_contention_r3: assert property (@(posedge clk) disable iff (rst)
    !ee_oe_n |-> !ee_dq_oe);

  p_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_we_n) |-> ($past(!ee_ce_n && ee_oe_n && ee_dq_oe)
                        && $stable(ee_dq_o) && $stable(ee_addr)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_we_n) |-> (!ee_ce_n && ee_dq_oe && $stable(ee_dq_o) && $stable(ee_addr)));

  p_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_we_n) |-> (low_cnt == PULSE_CYC));

  p_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !ee_ce_n && !ee_oe_n) |-> (idle_cnt >= WAIT_CYC));

  p_dummy_read_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_we_n) |-> !pend);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

endmodule

bind ee_byte_updater ee_byte_updater_chk #(
  .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .WAIT_CYC(WAIT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .upd_done(upd_done), .ee_addr(ee_addr), .ee_dq_o(ee_dq_o),
  .ee_dq_oe(ee_dq_oe), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n)
);

// File: tb/sim_ee_byte_updater.sv
module sim_ee_byte_updater;

  localparam int AW = 11, DW = 8;
  localparam int CLK_HZ = 1_000_000, PROG_US = 20, WE_NS = 3000, RD_NS = 2000;
  localparam int P = 3, W = 20, R = 2;
  localparam int LAT = 2 * (P + 2) + 2 * W + 2 * R + (R + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          upd_done, upd_err;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_dq_o, ee_dq_i;
  logic          ee_dq_oe, ee_ce_n, ee_oe_n, ee_we_n;

  ee_byte_updater #(
    .CLK_HZ(CLK_HZ), .AW(AW), .DW(DW), .PROG_US(PROG_US),
    .WE_NS(WE_NS), .RD_NS(RD_NS), .VERIFY_EN(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .upd_done(upd_done), .upd_err(upd_err),
    .ee_addr(ee_addr), .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe), .ee_dq_i(ee_dq_i),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n)
  );

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  bit            erased [0:(1<<AW)-1];
  logic [DW-1:0] stuck_mask = '0;
  bit  prev_we = 1'b1, pend = 1'b0;
  int  gap = W, lowcnt = 0, pulses = 0;
  int  v2 = 0, v3 = 0, v4 = 0, v5 = 0, v6 = 0;

  initial for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; erased[i] = 1'b0; end

  assign ee_dq_i = (!ee_ce_n && !ee_oe_n) ? (mem[ee_addr] | stuck_mask) : '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (!ee_we_n) begin
        if (ee_ce_n || !ee_oe_n || !ee_dq_oe) v3++;
        if (prev_we) begin
          pulses++;
          if (pend) v6++;
          if (ee_dq_o == '1) begin
            mem[ee_addr] = '1; erased[ee_addr] = 1'b1;
          end else begin
            if (!erased[ee_addr]) v2++;
            mem[ee_addr] = mem[ee_addr] & ee_dq_o;
            erased[ee_addr] = 1'b0;
          end
          pend = 1'b1;
        end
        lowcnt++;
        gap = 0;
      end else begin
        if (!prev_we) begin
          if (lowcnt != P) v4++;
          lowcnt = 0;
        end
        if (ee_ce_n && gap < 1000) gap++;
        if (!ee_ce_n && !ee_oe_n) begin
          if (pend && gap < W) v5++;
          pend = 1'b0;
        end
      end
      prev_we = ee_we_n;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit            err;
    longint        t0;
  } exp_t;
  exp_t q[$];
  int   last_pulses = 0;
  int   ready_busy  = 0;

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, bit err);
    exp_t e;
    bit acc;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    forever begin
      acc = req_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    e.a = a; e.d = d; e.err = err; e.t0 = cyc;
    q.push_back(e);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && req_ready && !upd_done) ready_busy++;
      if (upd_done) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc - e.t0 == LAT, "R9", "done latency", cyc - e.t0, LAT);
          check(upd_err == e.err, "R8", "readback error flag", upd_err, e.err);
          check(mem[e.a] == e.d, "R7", "stored byte", mem[e.a], e.d);
          check(pulses - last_pulses == 2, "R2", "write pulses per update",
                pulses - last_pulses, 2);
          last_pulses = pulses;
          check(v2 == 0, "R2", "write to a byte not erased", v2, 0);
          check(v3 == 0, "R3", "enable gating during pulse", v3, 0);
          check(v4 == 0, "R4", "pulse width violations", v4, 0);
          check(v5 == 0, "R5", "read inside programming wait", v5, 0);
          check(v6 == 0, "R6", "pulse without dummy read", v6, 0);
          check(ready_busy == 0, "R1", "ready while busy", ready_busy, 0);
          check(!req_ready, "R1", "ready during done", req_ready, 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", 20000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(ee_ce_n && ee_oe_n && ee_we_n, "R10", "strobes idle in reset",
          {ee_ce_n, ee_oe_n, ee_we_n}, 3'b111);
    check(!ee_dq_oe, "R10", "bus released in reset", ee_dq_oe, 0);
    check(req_ready, "R10", "ready in reset", req_ready, 1);
    check(!upd_done && !upd_err, "R10", "done/err low in reset", {upd_done, upd_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R1", "ready when idle", req_ready, 1);

    send(11'h000, 8'hA5, 1'b0);
    send(11'h7FF, 8'h00, 1'b0);
    send(11'h005, 8'hFF, 1'b0);
    send(11'h000, 8'h3C, 1'b0);   // overwrite needs the erase (R2, R7)
    wait (q.size() == 0);
    @(negedge clk);
    stuck_mask = 8'h01;           // read-back corrupted: R8 mismatch
    send(11'h007, 8'h00, 1'b1);
    wait (q.size() == 0);
    @(negedge clk);
    stuck_mask = 8'h00;
    send(11'h123, 8'h5A, 1'b0);   // back-to-back pair, flag clears (R8)
    send(11'h124, 8'hC3, 1'b0);
    wait (q.size() == 0);
    repeat (5) @(negedge clk);
    check(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe, "R3", "pins idle after run",
          {ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe}, 4'b1110);
    finish_run();
  end

endmodule